// File: doc/BRIEF.md
# Superstrip-Indexed Hit Organizer

This block keeps the full-resolution silicon hits of one event in a form that can be looked up by coarse superstrip address. Eight layer channels run side by side. Each channel takes at most one hit per clock, and every hit arrives with the superstrip it falls in. The channel appends the hit to a memory and prepends it to a chain kept for that superstrip, so the newest hit for a superstrip is always found from a head-pointer table. Because of this, a lookup never has to scan memory.

Roads come in on a valid/ready stream. Each road names one superstrip per layer, and roads queue in a small FIFO while readout is busy. For each road the sequencer visits layers in ascending order and follows that layer's chain, emitting one record per stored hit. If the requested superstrip holds nothing on a layer, it emits a single no-hit record for that layer. The final record of the road carries an end-of-road flag. The output stream stalls cleanly whenever the consumer holds ready low. The road input deasserts ready only when the queue is full.

A one-cycle end-of-event pulse empties the database by clearing a per-superstrip live bitmap and the write pointers. The stored words themselves are left in place. Hit inputs have no back-pressure. A layer whose memory is full drops further hits and raises a sticky overflow flag until the next end-of-event. The end-of-event pulse must be issued only while no road is pending or being read out.

Top module: `sshit_organizer`

## Requirements
- R1: Every layer whose bit in `hit_valid` is high stores one hit per clock. All layers can do so in the same cycle, and the hit inputs never stall. Layer l uses `hit_ss[l*SS_W +: SS_W]` and `hit_data[l*HIT_W +: HIT_W]`.
- R2: A road is read out layer by layer in ascending order, 0 to LAYERS-1. On layer l it emits one record for each stored hit whose superstrip equals `road_ss[l*SS_W +: SS_W]`, with `out_layer` = l, `out_hit` = the stored value and `out_nohit` = 0. No hit from another layer or another superstrip appears.
- R3: Hits that share a superstrip on one layer come out newest first, in reverse order of arrival.
- R4: A layer with no stored hit for the requested superstrip produces exactly one record, with `out_nohit` = 1 and `out_hit` = 0.
- R5: `out_last` is 1 on the final record of each road and on no other record. That final record always belongs to layer LAYERS-1.
- R6: While `out_valid` is 1 and `out_ready` is 0, the output record stays unchanged.
- R7: A road is taken on a cycle where `road_valid` and `road_ready` are both 1. ROAD_DEPTH roads can wait in the queue while one more is being read out. `road_ready` is 0 while the queue is full, and roads offered then are not taken. Roads are served in the order they were taken.
- R8: A cycle with `event_end` = 1 empties all layers: every superstrip reads as empty afterwards, all overflow flags clear, and hits presented in that same cycle are discarded. Hits after it are stored from an empty memory.
- R9: Each layer keeps at most HIT_DEPTH hits per event. Hits beyond that are dropped, earlier ones are kept, and `overflow[l]` goes to 1 one cycle later and stays there until `event_end`.
- R10: After reset `out_valid` = 0, `road_ready` = 1, `overflow` = 0 and every layer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_valid | input | LAYERS | Per-layer hit strobe |
| hit_ss | input | LAYERS*SS_W | Per-layer superstrip address of the hit |
| hit_data | input | LAYERS*HIT_W | Per-layer full-resolution hit value |
| event_end | input | 1 | End-of-event pulse, empties the database |
| overflow | output | LAYERS | Per-layer sticky overflow for the current event |
| road_valid | input | 1 | Road request valid |
| road_ready | output | 1 | Road queue has room |
| road_ss | input | LAYERS*SS_W | Requested superstrip per layer |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Consumer accepts the record |
| out_layer | output | clog2(LAYERS) | Layer of the record |
| out_hit | output | HIT_W | Hit value, 0 on a no-hit record |
| out_nohit | output | 1 | Layer had no hit for the road's superstrip |
| out_last | output | 1 | Final record of the road |

## Verification
The hardest state to reach from the ports is a full road queue, which requires the readout to be stuck on a road while the bench keeps offering more. The bench gets there by holding `out_ready` low, pushing roads until `road_ready` drops, and offering one extra road that must not be taken. The second hard case is layer overflow followed by an end-of-event that only clears the live bitmap. The bench writes past the memory depth on one layer, reads that superstrip back, clears, and reads it again to confirm that the old chain has disappeared and that new hits land in the emptied memory.

// File: rtl/sshit_pkg.sv
package sshit_pkg;
  // Readout sequencer state: idle, or walking the chains of a road
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_WALK = 1'b1} seq_state_t;
endpackage

// File: rtl/sshit_layer_store.sv
module sshit_layer_store #(
  parameter int SS_W  = 6,
  parameter int HIT_W = 16,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [SS_W-1:0]  wr_ss,
  input  logic [HIT_W-1:0] wr_hit,
  input  logic [SS_W-1:0]  rd_ss,
  output logic [$clog2(DEPTH)-1:0] head_ptr,
  output logic             head_ok,
  input  logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic [HIT_W-1:0] rd_hit,
  output logic [$clog2(DEPTH)-1:0] rd_next,
  output logic             rd_next_ok,
  output logic             overflow
);
  localparam int NSS = 1 << SS_W;
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;

  logic [NSS-1:0]   ss_live;
  logic [AW-1:0]    head_tab [NSS];
  logic [HIT_W-1:0] hit_mem  [DEPTH];
  logic [AW-1:0]    next_mem [DEPTH];
  logic             nok_mem  [DEPTH];
  logic [CW-1:0]    fill;
  logic             full;
  logic             do_store;

  assign full     = (fill == CW'(DEPTH));
  assign do_store = !clear && wr_en && !full;

  // live bitmap, fill pointer and overflow flag: reset and cleared per event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_live  <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else if (clear) begin
      ss_live  <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else if (wr_en) begin
      if (full) begin
        overflow <= 1'b1;
      end else begin
        ss_live[wr_ss] <= 1'b1;
        fill           <= fill + CW'(1);
      end
    end
  end

  // storage words: never cleared, validity comes from the bitmap
  always_ff @(posedge clk) begin
    if (do_store) begin
      hit_mem[fill[AW-1:0]]  <= wr_hit;
      next_mem[fill[AW-1:0]] <= head_tab[wr_ss];
      nok_mem[fill[AW-1:0]]  <= ss_live[wr_ss];
      head_tab[wr_ss]        <= fill[AW-1:0];
    end
  end

  assign head_ptr   = head_tab[rd_ss];
  assign head_ok    = ss_live[rd_ss];
  assign rd_hit     = hit_mem[rd_ptr];
  assign rd_next    = next_mem[rd_ptr];
  assign rd_next_ok = nok_mem[rd_ptr];
endmodule

// File: rtl/sshit_road_fifo.sv
module sshit_road_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         avail,
  output logic [W-1:0] head_data,
  input  logic         pop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] wr_ix, rd_ix;
  logic [CW-1:0] count;
  logic          push, take;

  assign in_ready  = (count != CW'(DEPTH));
  assign avail     = (count != '0);
  assign push      = in_valid && in_ready;
  assign take      = pop && avail;
  assign head_data = slots[rd_ix];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ix <= '0;
      rd_ix <= '0;
      count <= '0;
    end else begin
      if (push) wr_ix <= wr_ix + AW'(1);
      if (take) rd_ix <= rd_ix + AW'(1);
      if (push && !take)      count <= count + CW'(1);
      else if (take && !push) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_ix] <= in_data;
  end
endmodule

// File: rtl/sshit_readout_seq.sv
module sshit_readout_seq
  import sshit_pkg::*;
#(
  parameter int LAYERS = 8,
  parameter int SS_W   = 6,
  parameter int HIT_W  = 16,
  parameter int AW     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     road_avail,
  input  logic [LAYERS*SS_W-1:0]   road_data,
  output logic                     road_pop,
  output logic [LAYERS*SS_W-1:0]   rd_ss_all,
  input  logic [LAYERS*AW-1:0]     head_ptr_all,
  input  logic [LAYERS-1:0]        head_ok_all,
  output logic [AW-1:0]            rd_ptr,
  input  logic [LAYERS*HIT_W-1:0]  ent_hit_all,
  input  logic [LAYERS*AW-1:0]     ent_next_all,
  input  logic [LAYERS-1:0]        ent_nok_all,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [$clog2(LAYERS)-1:0] out_layer,
  output logic [HIT_W-1:0]         out_hit,
  output logic                     out_nohit,
  output logic                     out_last
);
  localparam int LW = $clog2(LAYERS);

  seq_state_t             state;
  logic [LW-1:0]          lay;
  logic [AW-1:0]          ptr;
  logic                   ok;
  logic [LAYERS*SS_W-1:0] road_q;

  logic          busy, fire, layer_done, final_layer, advance;
  logic [LW-1:0] tgt_layer;
  logic [AW-1:0] tgt_head;
  logic          tgt_ok;
  logic [HIT_W-1:0] cur_hit;

  assign busy        = (state == SEQ_WALK);
  assign fire        = busy && out_ready;
  assign cur_hit     = ent_hit_all[int'(lay)*HIT_W +: HIT_W];
  assign layer_done  = !ok || !ent_nok_all[lay];
  assign final_layer = (lay == LW'(LAYERS-1));
  assign road_pop    = road_avail && (!busy || (fire && layer_done && final_layer));
  assign advance     = fire && layer_done && !final_layer;
  assign tgt_layer   = road_pop ? '0 : lay + LW'(1);
  assign rd_ss_all   = road_pop ? road_data : road_q;
  assign tgt_head    = head_ptr_all[int'(tgt_layer)*AW +: AW];
  assign tgt_ok      = head_ok_all[tgt_layer];
  assign rd_ptr      = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      lay    <= '0;
      ptr    <= '0;
      ok     <= 1'b0;
      road_q <= '0;
    end else if (road_pop) begin
      state  <= SEQ_WALK;
      road_q <= road_data;
      lay    <= '0;
      ptr    <= tgt_head;
      ok     <= tgt_ok;
    end else if (advance) begin
      lay <= tgt_layer;
      ptr <= tgt_head;
      ok  <= tgt_ok;
    end else if (fire) begin
      if (!layer_done) ptr <= ent_next_all[int'(lay)*AW +: AW];
      else             state <= SEQ_IDLE;
    end
  end

  assign out_valid = busy;
  assign out_layer = lay;
  assign out_hit   = ok ? cur_hit : '0;
  assign out_nohit = !ok;
  assign out_last  = busy && layer_done && final_layer;
endmodule

// File: rtl/sshit_organizer.sv
module sshit_organizer #(
  parameter int LAYERS     = 8,
  parameter int SS_W       = 6,
  parameter int HIT_W      = 16,
  parameter int HIT_DEPTH  = 16,
  parameter int ROAD_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LAYERS-1:0]         hit_valid,
  input  logic [LAYERS*SS_W-1:0]    hit_ss,
  input  logic [LAYERS*HIT_W-1:0]   hit_data,
  input  logic                      event_end,
  output logic [LAYERS-1:0]         overflow,
  input  logic                      road_valid,
  output logic                      road_ready,
  input  logic [LAYERS*SS_W-1:0]    road_ss,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [$clog2(LAYERS)-1:0] out_layer,
  output logic [HIT_W-1:0]          out_hit,
  output logic                      out_nohit,
  output logic                      out_last
);
  localparam int AW = $clog2(HIT_DEPTH);
  localparam int RW = LAYERS * SS_W;

  logic          road_avail, road_pop;
  logic [RW-1:0] road_head, rd_ss_all;
  logic [LAYERS*AW-1:0]    head_ptr_all, ent_next_all;
  logic [LAYERS-1:0]       head_ok_all, ent_nok_all;
  logic [LAYERS*HIT_W-1:0] ent_hit_all;
  logic [AW-1:0]           rd_ptr;

  sshit_road_fifo #(.W(RW), .DEPTH(ROAD_DEPTH)) u_roads (
    .clk(clk), .rst_n(rst_n),
    .in_valid(road_valid), .in_ready(road_ready), .in_data(road_ss),
    .avail(road_avail), .head_data(road_head), .pop(road_pop)
  );

  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    sshit_layer_store #(.SS_W(SS_W), .HIT_W(HIT_W), .DEPTH(HIT_DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(event_end),
      .wr_en(hit_valid[l]),
      .wr_ss(hit_ss[l*SS_W +: SS_W]),
      .wr_hit(hit_data[l*HIT_W +: HIT_W]),
      .rd_ss(rd_ss_all[l*SS_W +: SS_W]),
      .head_ptr(head_ptr_all[l*AW +: AW]),
      .head_ok(head_ok_all[l]),
      .rd_ptr(rd_ptr),
      .rd_hit(ent_hit_all[l*HIT_W +: HIT_W]),
      .rd_next(ent_next_all[l*AW +: AW]),
      .rd_next_ok(ent_nok_all[l]),
      .overflow(overflow[l])
    );
  end

  sshit_readout_seq #(.LAYERS(LAYERS), .SS_W(SS_W), .HIT_W(HIT_W), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .road_avail(road_avail), .road_data(road_head), .road_pop(road_pop),
    .rd_ss_all(rd_ss_all),
    .head_ptr_all(head_ptr_all), .head_ok_all(head_ok_all),
    .rd_ptr(rd_ptr),
    .ent_hit_all(ent_hit_all), .ent_next_all(ent_next_all), .ent_nok_all(ent_nok_all),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_layer(out_layer), .out_hit(out_hit),
    .out_nohit(out_nohit), .out_last(out_last)
  );
endmodule

// File: rtl/sshit_organizer_chk.sv
module sshit_organizer_chk #(
  parameter int LAYERS = 8,
  parameter int HIT_W  = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      event_end,
  input logic [LAYERS-1:0]         overflow,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [$clog2(LAYERS)-1:0] out_layer,
  input logic [HIT_W-1:0]          out_hit,
  input logic                      out_nohit,
  input logic                      out_last
);
  localparam int LW = $clog2(LAYERS);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !event_end) |=>
      (out_valid && $stable(out_layer) && $stable(out_hit) &&
       $stable(out_nohit) && $stable(out_last)));

  assert_last_layer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_layer == LW'(LAYERS-1)));

  assert_nohit_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nohit) |-> (out_hit == '0));

  assert_layer_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_layer >= $past(out_layer)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    event_end |=> (overflow == '0));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !event_end |=> ((overflow & $past(overflow)) == $past(overflow)));
endmodule

bind sshit_organizer sshit_organizer_chk #(.LAYERS(LAYERS), .HIT_W(HIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .event_end(event_end), .overflow(overflow),
  .out_valid(out_valid), .out_ready(out_ready), .out_layer(out_layer),
  .out_hit(out_hit), .out_nohit(out_nohit), .out_last(out_last)
);

// File: tb/tb_sshit_organizer.sv
`timescale 1ns/1ps
module tb_sshit_organizer;
  localparam int L   = 8;
  localparam int SSW = 6;
  localparam int HW  = 16;
  localparam int HD  = 16;
  localparam int RD  = 4;
  localparam int LW  = 3;
  localparam int RECW = 2 + LW + HW;

  logic clk, rst_n;
  logic [L-1:0]     hit_valid;
  logic [L*SSW-1:0] hit_ss;
  logic [L*HW-1:0]  hit_data;
  logic             event_end;
  logic [L-1:0]     overflow;
  logic             road_valid, road_ready;
  logic [L*SSW-1:0] road_ss;
  logic             out_valid, out_ready;
  logic [LW-1:0]    out_layer;
  logic [HW-1:0]    out_hit;
  logic             out_nohit, out_last;

  sshit_organizer #(.LAYERS(L), .SS_W(SSW), .HIT_W(HW), .HIT_DEPTH(HD), .ROAD_DEPTH(RD)) dut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ss(hit_ss), .hit_data(hit_data),
    .event_end(event_end), .overflow(overflow),
    .road_valid(road_valid), .road_ready(road_ready), .road_ss(road_ss),
    .out_valid(out_valid), .out_ready(out_ready), .out_layer(out_layer),
    .out_hit(out_hit), .out_nohit(out_nohit), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference model: per-layer arrival list, scanned newest first
  int             m_cnt [L];
  logic [SSW-1:0] m_ss  [L][HD];
  logic [HW-1:0]  m_hit [L][HD];
  logic [RECW-1:0] expq [$];
  int rdy_mode = 0; // 0 always ready, 1 never, 2 pseudo-random

  function automatic logic [L*SSW-1:0] ss_same(input int s);
    logic [L*SSW-1:0] v;
    for (int l = 0; l < L; l++) v[l*SSW +: SSW] = SSW'(s);
    return v;
  endfunction

  function automatic logic [L*SSW-1:0] ss_step(input int base);
    logic [L*SSW-1:0] v;
    for (int l = 0; l < L; l++) v[l*SSW +: SSW] = SSW'(base + l);
    return v;
  endfunction

  function automatic logic [L*HW-1:0] data_tag(input int ph, input int i);
    logic [L*HW-1:0] v;
    for (int l = 0; l < L; l++) v[l*HW +: HW] = {4'(l), 4'(ph), 8'(i)};
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one write cycle; caller stands just after a rising edge
  task automatic hit_cycle(input logic [L-1:0] v, input logic [L*SSW-1:0] ss,
                           input logic [L*HW-1:0] d, input logic eoe);
    hit_valid = v; hit_ss = ss; hit_data = d; event_end = eoe;
    for (int l = 0; l < L; l++) begin
      if (eoe) m_cnt[l] = 0;
      else if (v[l] && m_cnt[l] < HD) begin
        m_ss[l][m_cnt[l]]  = ss[l*SSW +: SSW];
        m_hit[l][m_cnt[l]] = d[l*HW +: HW];
        m_cnt[l]++;
      end
    end
    @(posedge clk); #1;
    hit_valid = '0; event_end = 1'b0;
  endtask

  // driver: queue the expected records, then hand the road over
  task automatic send_road(input logic [L*SSW-1:0] ss);
    logic [RECW-1:0] tmp [$];
    for (int l = 0; l < L; l++) begin
      int found = 0;
      for (int i = m_cnt[l] - 1; i >= 0; i--) begin
        if (m_ss[l][i] == ss[l*SSW +: SSW]) begin
          tmp.push_back({1'b0, 1'b0, LW'(l), m_hit[l][i]});
          found++;
        end
      end
      if (found == 0) tmp.push_back({1'b0, 1'b1, LW'(l), HW'(0)});
    end
    tmp[tmp.size()-1] = tmp[tmp.size()-1] | {1'b1, {(RECW-1){1'b0}}};
    foreach (tmp[k]) expq.push_back(tmp[k]);
    road_valid = 1'b1; road_ss = ss;
    @(negedge clk);
    while (!road_ready) @(negedge clk);
    @(posedge clk); #1;
    road_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    @(negedge clk);
    while ((expq.size() != 0 || out_valid) && n < 3000) begin
      @(negedge clk); n++;
    end
    check("R2 all records delivered", 64'(expq.size()), 64'd0);
    repeat (3) @(negedge clk);
    check("R5 nothing after last record", 64'(out_valid), 64'd0);
    @(posedge clk); #1;
  endtask

  // ready driver, changes just after the rising edge
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = 1'b0;
        default: out_ready = ($urandom % 3) != 0;
      endcase
    end
  end

  // monitor: compares every transferred record and every stall
  logic            stall_pend = 1'b0;
  logic [RECW-1:0] stall_rec;
  always @(negedge clk) begin
    logic [RECW-1:0] cur, e;
    string tag;
    cur = {out_last, out_nohit, out_layer, out_hit};
    if (rst_n) begin
      if (stall_pend) begin
        checks++;
        if (!out_valid || cur !== stall_rec) begin
          errors++;
          $display("FAIL R6 held record: actual %0h expected %0h", cur, stall_rec);
        end
      end
      stall_pend = out_valid && !out_ready;
      stall_rec  = cur;
      if (out_valid && out_ready) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected record: actual %0h expected none", cur);
        end else begin
          e = expq.pop_front();
          tag = e[RECW-1] ? "R5" : (e[RECW-2] ? "R4" : "R2/R3");
          if (cur !== e) begin
            errors++;
            $display("FAIL %s record: actual %0h expected %0h", tag, cur, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hit_valid = '0; hit_ss = '0; hit_data = '0; event_end = 1'b0;
    road_valid = 1'b0; road_ss = '0;
    for (int l = 0; l < L; l++) m_cnt[l] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R10 out_valid", 64'(out_valid), 64'd0);
    check("R10 road_ready", 64'(road_ready), 64'd1);
    check("R10 overflow", 64'(overflow), 64'd0);
    @(posedge clk); #1;
    // empty store right after reset: every layer is a no-hit record (R10)
    send_road(ss_step(3));
    drain();

    // R1: all layers in parallel every cycle; R3: three hits per superstrip
    rdy_mode = 2;
    for (int i = 0; i < 3; i++) hit_cycle('1, ss_step(1), data_tag(1, i), 1'b0);
    hit_cycle(8'b0101_0101, ss_same(20), data_tag(2, 0), 1'b0);
    send_road(ss_step(1));   // R2, R3
    send_road(ss_same(20));  // R2 on even layers, R4 on odd layers
    send_road(ss_same(40));  // R4 everywhere, R5 on layer 7
    send_road(ss_step(2));   // mixed: layer l asks for l+2
    drain();

    // R7: stall readout and fill the road queue
    rdy_mode = 1;
    for (int k = 0; k < RD + 1; k++) send_road((k % 2) ? ss_same(20) : ss_step(1));
    @(negedge clk);
    check("R7 road_ready low when full", 64'(road_ready), 64'd0);
    @(posedge clk); #1;
    road_valid = 1'b1; road_ss = ss_same(33);   // must not be taken (R7)
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 ready stays low", 64'(road_ready), 64'd0);
    end
    @(posedge clk); #1;
    road_valid = 1'b0;
    rdy_mode = 2;
    drain();

    // R8: end-of-event with a simultaneous hit
    rdy_mode = 0;
    hit_cycle('1, ss_same(7), data_tag(3, 0), 1'b1);
    send_road(ss_step(1));
    send_road(ss_same(7));
    drain();

    // R9: overflow on layer 3 only
    hit_cycle(8'b0000_0001, ss_same(5), data_tag(4, 99), 1'b0);
    for (int i = 0; i < HD + 2; i++) hit_cycle(8'b0000_1000, ss_same(5), data_tag(5, i), 1'b0);
    @(negedge clk);
    check("R9 overflow flag", 64'(overflow), 64'h08);
    @(posedge clk); #1;
    rdy_mode = 2;
    send_road(ss_same(5));
    drain();
    @(negedge clk);
    check("R9 overflow sticky", 64'(overflow), 64'h08);
    @(posedge clk); #1;
    hit_cycle('0, '0, '0, 1'b1);
    @(negedge clk);
    check("R8 overflow cleared", 64'(overflow), 64'd0);
    @(posedge clk); #1;
    send_road(ss_same(5));
    drain();
    hit_cycle(8'b0000_1000, ss_same(5), data_tag(6, 1), 1'b0);
    hit_cycle(8'b1000_0000, ss_same(9), data_tag(6, 2), 1'b0);
    send_road(ss_same(5));
    send_road(ss_same(9));
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule